// File: doc/BRIEF.md
# Single-wire bus ROM command selector

This block is the network layer of a slave on a single-wire open-drain bus. After every bus reset it collects an 8-bit ROM command, one bit per time slot, least significant bit first, and carries it out against a 64-bit device identifier that is fixed by a parameter. The device either opens access to the function layer through `select` or goes quiet until the next bus reset.

A bit engine below this block turns line activity into events. It reports each finished time slot on `slot_done`, together with the level it sampled on `rx_bit`. Before each slot, `tx_req` tells the engine whether the slot is a device-driven read slot. In that case `tx_bit` low means the engine pulls the line low. The block keeps a resume flag across bus resets. Only the block's own `rst_n` clears that flag.

The identifier holds an 8-bit family code in bits 7:0, a 48-bit serial number in bits 55:8 and an 8-bit check byte in bits 63:56. Identifier bits go out and are compared in ascending bit order.

Top module: `owire_rom_select`

## Requirements
- R1: After a bus reset the block takes exactly 8 slots as a command, LSB first. During these slots `tx_req`, `select` and `quiet` stay low.
- R2: Command 33h drives `tx_req` for 64 slots and sends identifier bit i on `tx_bit` in slot i. It then raises `select` and clears the resume flag.
- R3: Command 55h takes 64 master bits. When all of them equal the identifier in order, `select` rises after the last one and the resume flag is set.
- R4: Under 55h, the first master bit that differs from the identifier raises `quiet` after that slot. The master bits that follow have no effect on `select`, `quiet` or `tx_req`.
- R5: Command F0h runs one group of three slots per identifier bit, from bit 0 upward. Slot 1 is a read slot that sends the bit. Slot 2 is a read slot that sends the bit's complement. Slot 3 is a write slot in which the master states the chosen bit. After 64 groups that all match, `select` rises and the resume flag is set.
- R6: Under F0h, a chosen bit that differs from the identifier raises `quiet`, and the device drives no further read slots.
- R7: Command CCh raises `select` right after the command and clears the resume flag.
- R8: Command A5h raises `select` when the resume flag is set and raises `quiet` when it is clear.
- R9: Receiving 55h or F0h clears the resume flag, even when the addressing then fails.
- R10: Any other command code raises `quiet`.
- R11: `bus_reset` at any point returns the block to command collection on the next cycle and keeps the resume flag. `rst_n` low clears the flag. `bus_reset` takes priority over `slot_done` in the same cycle.
- R12: Once `select` or `quiet` is high, it stays high until `bus_reset`, whatever slots arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears the resume flag |
| bus_reset | input | 1 | One-cycle pulse: a bus reset was detected |
| slot_done | input | 1 | One-cycle pulse: a time slot has completed |
| rx_bit | input | 1 | Line level sampled in the completed slot |
| tx_req | output | 1 | The next slot is a device-driven read slot |
| tx_bit | output | 1 | Level to send in the read slot (0 means pull low) |
| select | output | 1 | Function layer access granted |
| quiet | output | 1 | Device ignores the bus until the next bus reset |

## Verification
The hardest situations to reach are the ones where the outcome depends on history: the resume flag left behind by an earlier transaction, and a dropout on the very last identifier bit. The stimulus table chains transactions in a fixed order, so that every resume command meets a flag that the row before it set or cleared. Addressing rows can flip any chosen bit, including bit 63 under match and bit 0 under search. Directed cases abort a command part-way with a bus reset, and pulse `rst_n` to show that only the device reset forgets the flag.

// File: rtl/owire_rom_select.sv
module owire_rom_select #(
  parameter int ID_W = 64,
  parameter int CMD_W = 8,
  parameter logic [ID_W-1:0] DEV_ID = 64'h9C00_07E1_5AD3_4B28
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_reset,
  input  logic slot_done,
  input  logic rx_bit,
  output logic tx_req,
  output logic tx_bit,
  output logic select,
  output logic quiet
);
  localparam int IDX_W = (ID_W > CMD_W) ? $clog2(ID_W) : $clog2(CMD_W);
  localparam logic [IDX_W-1:0] ID_LAST  = IDX_W'(ID_W - 1);
  localparam logic [IDX_W-1:0] CMD_LAST = IDX_W'(CMD_W - 1);
  localparam logic [CMD_W-1:0] C_READ   = CMD_W'(8'h33);
  localparam logic [CMD_W-1:0] C_MATCH  = CMD_W'(8'h55);
  localparam logic [CMD_W-1:0] C_SEARCH = CMD_W'(8'hF0);
  localparam logic [CMD_W-1:0] C_SKIP   = CMD_W'(8'hCC);
  localparam logic [CMD_W-1:0] C_RESUME = CMD_W'(8'hA5);

  typedef enum logic [2:0] {
    S_CMD, S_READ, S_MATCH, S_STRUE, S_SCOMP, S_SDIR, S_SEL, S_QUIET
  } state_t;

  state_t           state;
  logic [IDX_W-1:0] cnt;
  logic [CMD_W-1:0] cmd_sr;
  logic             rflag;

  wire              id_bit  = DEV_ID[cnt];
  wire [CMD_W-1:0]  cmd_now = {rx_bit, cmd_sr[CMD_W-1:1]};
  wire              last_id = (cnt == ID_LAST);

  assign tx_req = (state == S_READ) || (state == S_STRUE) || (state == S_SCOMP);
  assign tx_bit = !tx_req || ((state == S_SCOMP) ? !id_bit : id_bit);
  assign select = (state == S_SEL);
  assign quiet  = (state == S_QUIET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_CMD;
      cnt    <= '0;
      cmd_sr <= '0;
      rflag  <= 1'b0;
    end else if (bus_reset) begin
      state  <= S_CMD;
      cnt    <= '0;
      cmd_sr <= '0;
    end else if (slot_done) begin
      case (state)
        S_CMD: begin
          cmd_sr <= cmd_now;
          if (cnt == CMD_LAST) begin
            cnt <= '0;
            case (cmd_now)
              C_READ:   begin state <= S_READ;  rflag <= 1'b0; end
              C_MATCH:  begin state <= S_MATCH; rflag <= 1'b0; end
              C_SEARCH: begin state <= S_STRUE; rflag <= 1'b0; end
              C_SKIP:   begin state <= S_SEL;   rflag <= 1'b0; end
              C_RESUME: state <= rflag ? S_SEL : S_QUIET;
              default:  state <= S_QUIET;
            endcase
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_READ: begin
          if (last_id) state <= S_SEL;
          else cnt <= cnt + 1'b1;
        end
        S_MATCH: begin
          if (rx_bit != id_bit) state <= S_QUIET;
          else if (last_id) begin state <= S_SEL; rflag <= 1'b1; end
          else cnt <= cnt + 1'b1;
        end
        S_STRUE: state <= S_SCOMP;
        S_SCOMP: state <= S_SDIR;
        S_SDIR: begin
          if (rx_bit != id_bit) state <= S_QUIET;
          else if (last_id) begin state <= S_SEL; rflag <= 1'b1; end
          else begin state <= S_STRUE; cnt <= cnt + 1'b1; end
        end
        default: state <= state;
      endcase
    end
  end
endmodule

// File: rtl/owire_rom_select_chk.sv
module owire_rom_select_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_reset,
  input logic slot_done,
  input logic tx_req,
  input logic tx_bit,
  input logic select,
  input logic quiet
);
  a_r11_reset_to_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> (!select && !quiet && !tx_req));

  a_r12_select_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (select && !bus_reset) |=> select);

  a_r12_quiet_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && !bus_reset) |=> quiet);

  a_r1_outputs_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({select, quiet, tx_req}));

  a_r2_tx_moves_on_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_done && !bus_reset) |=> $stable({tx_req, tx_bit, select, quiet}));
endmodule

bind owire_rom_select owire_rom_select_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .slot_done(slot_done),
  .tx_req(tx_req), .tx_bit(tx_bit), .select(select), .quiet(quiet)
);

// File: tb/owire_rom_select_tb.sv
module owire_rom_select_tb;
  localparam int CLK_P = 10;
  localparam logic [63:0] ID = 64'h9C00_07E1_5AD3_4B28;
  localparam int NV = 17;
  // {cmd[7:0], mode[1:0] (0 none, 1 exact id, 2 flip bit k), k[5:0], exp_sel, exp_quiet}
  localparam logic [17:0] VEC [NV] = '{
    {8'hA5, 2'd0, 6'd0,  1'b0, 1'b1},
    {8'hCC, 2'd0, 6'd0,  1'b1, 1'b0},
    {8'h55, 2'd1, 6'd0,  1'b1, 1'b0},
    {8'hA5, 2'd0, 6'd0,  1'b1, 1'b0},
    {8'h55, 2'd2, 6'd63, 1'b0, 1'b1},
    {8'hA5, 2'd0, 6'd0,  1'b0, 1'b1},
    {8'hF0, 2'd1, 6'd0,  1'b1, 1'b0},
    {8'hA5, 2'd0, 6'd0,  1'b1, 1'b0},
    {8'h33, 2'd0, 6'd0,  1'b1, 1'b0},
    {8'hA5, 2'd0, 6'd0,  1'b0, 1'b1},
    {8'hF0, 2'd1, 6'd0,  1'b1, 1'b0},
    {8'hF0, 2'd2, 6'd0,  1'b0, 1'b1},
    {8'hA5, 2'd0, 6'd0,  1'b0, 1'b1},
    {8'h3C, 2'd0, 6'd0,  1'b0, 1'b1},
    {8'h55, 2'd2, 6'd20, 1'b0, 1'b1},
    {8'hCC, 2'd0, 6'd0,  1'b1, 1'b0},
    {8'hA5, 2'd0, 6'd0,  1'b0, 1'b1}
  };

  logic clk = 0, rst_n = 0, bus_reset = 0, slot_done = 0, rx_bit = 1;
  logic tx_req, tx_bit, select, quiet;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  owire_rom_select u_dut (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .slot_done(slot_done),
    .rx_bit(rx_bit), .tx_req(tx_req), .tx_bit(tx_bit), .select(select), .quiet(quiet)
  );

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic slot(input logic b);
    rx_bit = b; slot_done = 1;
    @(negedge clk);
    slot_done = 0; rx_bit = 1;
  endtask

  task automatic breset();
    bus_reset = 1;
    @(negedge clk);
    bus_reset = 0;
  endtask

  task automatic send_cmd(input logic [7:0] c);
    logic bad = 0;
    for (int i = 0; i < 8; i++) begin
      if (tx_req || select || quiet) bad = 1;
      slot(c[i]);
    end
    check(!bad, "R1 command slots quiet", {61'd0, tx_req, select, quiet}, 64'd0);
  endtask

  task automatic run_row(input logic [17:0] v);
    logic [7:0] c = v[17:10];
    logic [1:0] mode = v[9:8];
    int k = int'(v[7:2]);
    logic bad = 0;
    logic dropped = 0;
    breset();
    send_cmd(c);
    if (c == 8'h33) begin
      for (int i = 0; i < 64; i++) begin
        if (!tx_req || tx_bit != ID[i]) bad = 1;
        slot(1'b1);
      end
      check(!bad, "R2 read id bits", {63'd0, bad}, 64'd0);
    end else if (c == 8'h55) begin
      for (int i = 0; i < 64; i++) begin
        if (tx_req) bad = 1;
        slot(ID[i] ^ (mode == 2'd2 && i == k));
        if (mode == 2'd2 && i >= k && !quiet) bad = 1;
      end
      check(!bad, mode == 2'd2 ? "R4 match dropout holds" : "R3 match slots", {63'd0, bad}, 64'd0);
    end else if (c == 8'hF0) begin
      for (int i = 0; i < 64 && !dropped; i++) begin
        if (!tx_req || tx_bit != ID[i]) bad = 1;
        slot(1'b1);
        if (!tx_req || tx_bit != !ID[i]) bad = 1;
        slot(1'b1);
        if (tx_req) bad = 1;
        slot(ID[i] ^ (mode == 2'd2 && i == k));
        if (mode == 2'd2 && i == k) begin
          dropped = 1;
          slot(1'b0);
          if (tx_req || !quiet) bad = 1;
        end
      end
      check(!bad, mode == 2'd2 ? "R6 search dropout" : "R5 search triplets", {63'd0, bad}, 64'd0);
    end
    check(select == v[1] && quiet == v[0], "R3 R5 R7 R8 R9 R10 row outcome",
          {62'd0, select, quiet}, {62'd0, v[1:0]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!tx_req && !select && !quiet && tx_bit, "R1 reset state",
          {60'd0, tx_req, tx_bit, select, quiet}, 64'h4);
    rst_n = 1;
    @(negedge clk);

    for (int r = 0; r < NV; r++) run_row(VEC[r]);

    // R12: quiet ignores further slots
    breset(); send_cmd(8'h3C);
    for (int i = 0; i < 20; i++) slot(i[0]);
    check(quiet && !select && !tx_req, "R12 quiet holds", {62'd0, select, quiet}, 64'd1);

    // R12: select holds
    breset(); send_cmd(8'hCC);
    for (int i = 0; i < 20; i++) slot(i[1]);
    check(select && !quiet && !tx_req, "R12 select holds", {62'd0, select, quiet}, 64'd2);

    // R11: reset mid-command keeps the flag
    run_row({8'h55, 2'd1, 6'd0, 1'b1, 1'b0});
    breset();
    slot(1'b1); slot(1'b0); slot(1'b1);
    breset();
    send_cmd(8'hA5);
    check(select, "R11 bus reset keeps flag", {63'd0, select}, 64'd1);

    // R11: reset priority over slot in same cycle
    breset(); send_cmd(8'h3C);
    bus_reset = 1; slot_done = 1; rx_bit = 0;
    @(negedge clk);
    bus_reset = 0; slot_done = 0; rx_bit = 1;
    check(!quiet && !select, "R11 reset priority", {62'd0, select, quiet}, 64'd0);
    send_cmd(8'hA5);
    check(select, "R11 flag after priority reset", {63'd0, select}, 64'd1);

    // R11: rst_n clears the flag
    rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    send_cmd(8'hA5);
    check(quiet && !select, "R11 rst_n clears flag", {62'd0, select, quiet}, 64'd1);

    // R9: search failing at bit 63 still clears flag
    run_row({8'h55, 2'd1, 6'd0, 1'b1, 1'b0});
    run_row({8'hF0, 2'd2, 6'd63, 1'b0, 1'b1});
    run_row({8'hA5, 2'd0, 6'd0, 1'b0, 1'b1});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule